// File: doc/BRIEF.md
# Signed Radix-4 Carry-Save Tree Multiplier

This block multiplies two signed two's-complement operands and returns the whole double-width product. It has no clock, no state and no handshake: the product is a pure function of the two inputs and settles within a single evaluation. A surrounding datapath registers the operands and the result wherever its own timing calls for it.

Internally, the multiplier operand is cut into overlapping three-bit windows, two bits apart. Each window picks one signed multiple of the multiplicand, with magnitude zero, one or two. All windows are decoded at once, so the default 40-bit operands give twenty partial products.

A negative multiple is formed by inverting the bits of the multiplicand. The missing +1 is placed as one extra bit below the next higher partial product. The +1 for the highest partial product goes in as one more small input word.

The rows are reduced by layers of independent 3:2 adder words, which never propagate a carry, until only one sum word and one carry word remain. A single carry-propagate addition then yields the product.

Top module: `booth_csa_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the signed product of `mcand_i` and `mplier_i`, taken over the full 2*OP_W bits.
- R2: When either operand is zero, `prod_o` is zero.
- R3: The most negative operand times itself gives exactly 2^(2*OP_W-2), which is positive. The double-width result never overflows.
- R4: Each multiplier window is written (upper, middle, lower). Upper is bit 2k+1, middle is bit 2k, and lower is bit 2k-1, with bit -1 taken as 0. The window selects the multiple as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. A window never selects magnitude one and magnitude two at the same time.
- R5: A multiplicand of -1 or of 2^(OP_W-1)-1 gives the correct product, whatever the multiplier.
- R6: A multiplier whose sign bit is set, including the most negative value, is decoded by the same window rule with no special top step, and gives the correct product.
- R7: When both operands are nonzero, the top bit of `prod_o` equals the XOR of the two operand sign bits.
- R8: Every 3:2 adder word keeps the sum of its three inputs modulo 2^(2*OP_W). Its carry word is shifted left by one, and any carry out of the top position is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | OP_W | Multiplicand, two's complement |
| mplier_i | input | OP_W | Multiplier, two's complement, recoded in windows |
| prod_o | output | 2*OP_W | Full signed product |

## Verification
The assertions are immediate checks that run after the combinational logic has settled. They take for granted that both operands hold known 0/1 values and stay steady while the logic is evaluated. The stimulus changes the operands only once per clock, on the rising edge, and reads the product on the falling edge, so every comparison sees settled values. Operands come from a generator and are always fully defined. They cover the extreme values, windows of every code, and random pairs.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } mult_sel_t;

    // words left after lv reduction layers starting from n inputs
    function automatic int tree_count(input int n, input int lv);
        int c;
        c = n;
        for (int i = 0; i < lv; i++) begin
            c = (c / 3) * 2 + (c % 3);
        end
        return c;
    endfunction

    // layers needed to reach two words
    function automatic int tree_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 2) begin
            c = (c / 3) * 2 + (c % 3);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/booth_sel.sv
module booth_sel
    import booth_mult_pkg::*;
(
    input  logic [2:0] trip_i,
    output mult_sel_t  sel_o
);
    logic up, mid, lo;

    always_comb begin
        up  = trip_i[2];
        mid = trip_i[1];
        lo  = trip_i[0];
        sel_o.one = mid ^ lo;
        sel_o.two = (up & ~mid & ~lo) | (~up & mid & lo);
        sel_o.neg = up & ~(mid & lo);
    end

    always_comb begin
        // R4
        sel_excl_chk: assert ($onehot0({sel_o.one, sel_o.two}))
            else $error("window selects both magnitudes");
        // R4
        neg_nonzero_chk: assert (!sel_o.neg || sel_o.one || sel_o.two)
            else $error("negative zero multiple selected");
    end
endmodule

// File: rtl/pp_row.sv
module pp_row
    import booth_mult_pkg::*;
#(
    parameter int OP_W = 40,
    parameter int W    = 80,
    parameter int IDX  = 0
) (
    input  logic [OP_W-1:0] mcand_i,
    input  mult_sel_t       sel_i,
    input  logic            prev_neg_i,
    output logic [W-1:0]    row_o
);
    localparam int SH   = 2 * IDX;
    localparam int CPOS = (IDX > 0) ? (2 * IDX - 2) : 0;
    localparam int EXT  = W - OP_W - 1;

    logic [OP_W:0] mag;
    logic [W-1:0]  ext;

    always_comb begin
        if (sel_i.two) begin
            mag = {mcand_i, 1'b0};
        end else if (sel_i.one) begin
            mag = {mcand_i[OP_W-1], mcand_i};
        end else begin
            mag = '0;
        end
        if (sel_i.neg) begin
            mag = ~mag;
        end
        ext   = {{EXT{mag[OP_W]}}, mag};
        row_o = ext << SH;
        // +1 of the row below, placed in the free slot under this row
        row_o[CPOS] = row_o[CPOS] | prev_neg_i;
    end
endmodule

// File: rtl/fa_word.sv
module fa_word #(
    parameter int W = 80
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);
    logic [W-1:0] maj;

    always_comb begin
        sum_o = a_i ^ b_i ^ c_i;
        maj   = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
        cy_o  = {maj[W-2:0], 1'b0};
    end

    always_comb begin
        // R8
        sum_keep_chk: assert (W'(sum_o + cy_o) == W'(a_i + b_i + c_i))
            else $error("3:2 word changed the total");
    end
endmodule

// File: rtl/csa_tree.sv
module csa_tree
    import booth_mult_pkg::*;
#(
    parameter int W    = 80,
    parameter int N_IN = 21
) (
    input  logic [W-1:0] rows_i [N_IN],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);
    localparam int NUM_LV = tree_levels(N_IN);

    for (genvar lv = 0; lv <= NUM_LV; lv++) begin : g_lv
        localparam int CNT = tree_count(N_IN, lv);
        logic [W-1:0] w [CNT];
        if (lv == 0) begin : g_in
            for (genvar k = 0; k < CNT; k++) begin : g_k
                assign w[k] = rows_i[k];
            end
        end else begin : g_red
            localparam int PREV = tree_count(N_IN, lv - 1);
            localparam int GRP  = PREV / 3;
            for (genvar g = 0; g < GRP; g++) begin : g_fa
                fa_word #(.W(W)) u_fa (
                    .a_i  (g_lv[lv-1].w[3*g]),
                    .b_i  (g_lv[lv-1].w[3*g+1]),
                    .c_i  (g_lv[lv-1].w[3*g+2]),
                    .sum_o(w[2*g]),
                    .cy_o (w[2*g+1])
                );
            end
            for (genvar k = 0; k < PREV % 3; k++) begin : g_pass
                assign w[2*GRP+k] = g_lv[lv-1].w[3*GRP+k];
            end
        end
    end

    assign sum_o = g_lv[NUM_LV].w[0];
    assign cy_o  = g_lv[NUM_LV].w[1];
endmodule

// File: rtl/booth_csa_mult.sv
module booth_csa_mult
    import booth_mult_pkg::*;
#(
    parameter int OP_W = 40
) (
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic [2*OP_W-1:0] prod_o
);
    localparam int W    = 2 * OP_W;
    localparam int N_PP = OP_W / 2;
    localparam int N_IN = N_PP + 1;

    mult_sel_t    sel  [N_PP];
    logic [W-1:0] rows [N_IN];
    logic [W-1:0] red_sum, red_cy;

    for (genvar k = 0; k < N_PP; k++) begin : g_pp
        logic [2:0] trip;
        logic       prev_neg;
        if (k == 0) begin : g_low
            assign trip     = {mplier_i[1], mplier_i[0], 1'b0};
            assign prev_neg = 1'b0;
        end else begin : g_up
            assign trip     = mplier_i[2*k+1 : 2*k-1];
            assign prev_neg = sel[k-1].neg;
        end
        booth_sel u_sel (
            .trip_i(trip),
            .sel_o (sel[k])
        );
        pp_row #(.OP_W(OP_W), .W(W), .IDX(k)) u_row (
            .mcand_i   (mcand_i),
            .sel_i     (sel[k]),
            .prev_neg_i(prev_neg),
            .row_o     (rows[k])
        );
    end

    // correction for the top row rides in one extra tree input
    assign rows[N_PP] = W'(sel[N_PP-1].neg) << (2 * (N_PP - 1));

    csa_tree #(.W(W), .N_IN(N_IN)) u_tree (
        .rows_i(rows),
        .sum_o (red_sum),
        .cy_o  (red_cy)
    );

    assign prod_o = red_sum + red_cy;

    logic signed [W-1:0] ref_prod;
    always_comb begin
        ref_prod = $signed({{OP_W{mcand_i[OP_W-1]}}, mcand_i})
                 * $signed({{OP_W{mplier_i[OP_W-1]}}, mplier_i});
        // R1
        prod_ref_chk: assert (prod_o == ref_prod)
            else $error("product mismatch");
        // R7
        prod_sign_chk: assert ((mcand_i == '0) || (mplier_i == '0)
                || (prod_o[W-1] == (mcand_i[OP_W-1] ^ mplier_i[OP_W-1])))
            else $error("product sign wrong");
    end
endmodule

// File: tb/booth_csa_mult_test.sv
module booth_csa_mult_test;
    localparam int OP_W = 40;
    localparam int W    = 2 * OP_W;
    localparam int MAXC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OP_W-1:0] a = '0;
    logic [OP_W-1:0] b = '0;
    logic [W-1:0]    p;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [W-1:0] expq [$];

    always #10 clk = ~clk;

    booth_csa_mult #(.OP_W(OP_W)) uut (
        .mcand_i (a),
        .mplier_i(b),
        .prod_o  (p)
    );

    function automatic logic [W-1:0] model(input logic [OP_W-1:0] x,
                                           input logic [OP_W-1:0] y);
        longint sx, sy;
        logic signed [W-1:0] r;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        r  = W'(sx) * W'(sy);
        return r;
    endfunction

    task automatic apply(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y,
                         input string tag);
        logic [W-1:0] e;
        @(posedge clk);
        a = x;
        b = y;
        expq.push_back(model(x, y));
        @(negedge clk);
        e = expq.pop_front();
        checks++;
        if (p !== e) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, x, y, p, e);
        end
    endtask

    task automatic sign_check(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
        logic es;
        apply(x, y, "R1");
        if (x != '0 && y != '0) begin
            es = x[OP_W-1] ^ y[OP_W-1];
            checks++;
            if (p[W-1] !== es) begin
                errors++;
                $display("FAIL R7 sign actual=%b expected=%b", p[W-1], es);
            end
        end
    endtask

    localparam logic [OP_W-1:0] MINV = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [OP_W-1:0] MAXV = {1'b0, {(OP_W-1){1'b1}}};
    localparam logic [OP_W-1:0] NEG1 = '1;

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2: idle operands give zero
        @(negedge clk);
        checks++;
        if (p !== '0) begin
            errors++;
            $display("FAIL R2 idle actual=%h expected=0", p);
        end
        apply('0, 40'h12345_6789A, "R2");
        apply(40'h80_0000_1234, '0, "R2");
        // R3
        apply(MINV, MINV, "R3");
        checks++;
        if (p !== (W'(1) << (W - 2))) begin
            errors++;
            $display("FAIL R3 actual=%h expected=%h", p, W'(1) << (W - 2));
        end
        apply(MINV, MAXV, "R3");
        // R5
        apply(NEG1, NEG1, "R5");
        apply(NEG1, MINV, "R5");
        apply(MAXV, MAXV, "R5");
        apply(MAXV, NEG1, "R5");
        apply(NEG1, 40'h3_1415_9265, "R5");
        // R6
        apply(40'h0F_F00F_0001, MINV, "R6");
        apply(40'hC3_A5A5_5A5A, 40'h80_0000_0001, "R6");
        apply(40'h12_3456_789A, 40'hFF_FFFF_FFFE, "R6");
        // R4: every window code appears in these multipliers
        apply(40'h7A_BCDE_F012, 40'h55_5555_5555, "R4");
        apply(40'h7A_BCDE_F012, 40'hAA_AAAA_AAAA, "R4");
        apply(40'h91_2345_6789, 40'h33_3333_3333, "R4");
        apply(40'h91_2345_6789, 40'hCC_CCCC_CCCC, "R4");
        apply(40'h00_0000_0001, 40'h66_6666_6666, "R4");
        apply(40'hFF_FFFF_FFFF, 40'h99_9999_9999, "R4");
        for (int k = 0; k < 8; k++) begin
            apply(MAXV, OP_W'(k), "R4");
            apply(MINV, OP_W'(k) << 37, "R4");
        end
        // R1 / R7 / R8 random pairs
        for (int n = 0; n < 3000; n++) begin
            logic [OP_W-1:0] x, y;
            x = {$urandom(), $urandom()};
            y = {$urandom(), $urandom()};
            if (n % 7 == 0) x = x & 40'h80_0000_00FF;
            if (n % 11 == 0) y = y | MINV;
            sign_check(x, y);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAXC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule